// File: doc/BRIEF.md
# Pipelined Table-Based Reciprocal Unit

This block approximates the fixed-point reciprocal of an unsigned 24-bit operand, returning roughly floor(2^24 / q) as a 25-bit value. It contains no divider. A priority leading-one detector first finds the position `s` of the most significant set bit of the operand. The eight bits just below that bit, zero-padded when the operand is short, address a 256-entry constant table of scaled reciprocals of the normalised mantissa. The table word is then shifted right by `s` to restore the scale.

It is intended for perspective-correct texture interpolation, where each pixel needs one reciprocal per clock. The unit is fully pipelined with three register stages: leading-one detection, table lookup, then denormalisation with zero saturation. It accepts one operand per clock and returns results in arrival order. There is no back-pressure: the consumer must take every result in the cycle its valid flag is high. A zero operand saturates to all ones.

Top module: `recip_pipe`

## Requirements
- R1: For any nonzero operand q, the absolute difference between `recip` and floor(2^24 / q) is at most (floor(2^24 / q) >> 7) + 2.
- R2: For q = 2^s (0 ≤ s ≤ 23), `recip` equals exactly 2^(24−s). For q = 1 this is 2^24, with bit 24 set and all other bits clear.
- R3: For q = 0, `recip` is all ones (0x1FFFFFF).
- R4: An operand sampled with `in_valid` high on rising edge n appears on the outputs, with `out_valid` high, after rising edge n+2. The latency is three register stages.
- R5: With `in_valid` held high on consecutive clocks, one result leaves per clock. Results keep the arrival order, and the number of results equals the number of accepted operands.
- R6: A clock on which `in_valid` is low produces, three stages later, a cycle with `out_valid` low. Bubbles keep their position in the stream.
- R7: While `rst_n` is low, `out_valid` is low. A reset during streaming discards every operand in flight, and no result emerges for them.
- R8: For nonzero operands below 512, the table index holds the operand exactly, and `recip` differs from floor(2^24 / q) by at most 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset that empties the pipeline |
| in_valid | input | 1 | Operand on `operand` is valid this cycle |
| operand | input | 24 | Unsigned divisor q |
| out_valid | output | 1 | `recip` carries a result this cycle |
| recip | output | 25 | Approximation of floor(2^24 / q), all ones for q = 0 |

## Verification
The hardest case to reach from the ports is a zero operand or a single-bit operand in the same cycle as bubbles and a reset that lands while all three stages hold live data. Reaching it depends on how the stream is ordered, not on which values are chosen. The stimulus sends directed edge values back to back: zero, one, every power of two, values just above powers of two, and the all-ones operand. It then sends a random stream whose operand widths vary and whose valid flag drops about one cycle in three. Finally it asserts reset with the pipeline full. A behavioural model tracks three pending slots and compares the valid flag and the value tolerance on every clock.

// File: rtl/recip_pkg.sv
package recip_pkg;

    localparam int DEF_Q_W   = 24;
    localparam int DEF_IDX_W = 8;
    localparam int DEF_SCALE = 24;

    // Rounded value of 2^(scale+idx_w) / (2^idx_w + idx), i.e. 2^scale / (1 + idx/2^idx_w)
    function automatic logic [63:0] table_word(input int idx, input int idx_w, input int scale);
        logic [63:0] num;
        logic [63:0] den;
        num = 64'd1 << (scale + idx_w);
        den = (64'd1 << idx_w) + 64'(idx);
        return (num + (den >> 1)) / den;
    endfunction

endpackage

// File: rtl/recip_lead_one.sv
module recip_lead_one #(
    parameter int Q_W   = recip_pkg::DEF_Q_W,
    parameter int IDX_W = recip_pkg::DEF_IDX_W,
    localparam int SH_W = $clog2(Q_W)
) (
    input  logic [Q_W-1:0]   q_val,
    output logic [SH_W-1:0]  msb_pos,
    output logic [IDX_W-1:0] mant_idx,
    output logic             is_zero
);

    logic [Q_W-1:0] norm;

    // priority scan: the highest set bit wins
    always_comb begin
        msb_pos = '0;
        for (int i = 0; i < Q_W; i++) begin
            if (q_val[i]) msb_pos = SH_W'(i);
        end
    end

    always_comb begin
        norm     = q_val << (SH_W'(Q_W - 1) - msb_pos);
        mant_idx = norm[Q_W-2 -: IDX_W];
        is_zero  = (q_val == '0);
    end

    // R1: the detected position really is the leading one
    always_comb begin
        if (q_val != '0) begin
            p_lead_pos_r1: assert ((q_val >> msb_pos) == Q_W'(1));
        end
    end

endmodule

// File: rtl/recip_table.sv
module recip_table #(
    parameter int IDX_W = recip_pkg::DEF_IDX_W,
    parameter int SCALE = recip_pkg::DEF_SCALE,
    localparam int OUT_W = SCALE + 1,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic [IDX_W-1:0] idx,
    output logic [OUT_W-1:0] mant
);

    logic [OUT_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        localparam logic [63:0] WORD = recip_pkg::table_word(g, IDX_W, SCALE);
        assign rom[g] = WORD[OUT_W-1:0];
    end

    assign mant = rom[idx];

    // R2: the unit mantissa must map to the exact scale value
    always_comb begin
        if (idx == '0) begin
            p_unit_entry_r2: assert (mant == (OUT_W'(1) << SCALE));
        end
    end

endmodule

// File: rtl/recip_denorm.sv
module recip_denorm #(
    parameter int Q_W   = recip_pkg::DEF_Q_W,
    parameter int SCALE = recip_pkg::DEF_SCALE,
    localparam int OUT_W = SCALE + 1,
    localparam int SH_W  = $clog2(Q_W)
) (
    input  logic [OUT_W-1:0] mant,
    input  logic [SH_W-1:0]  shift,
    input  logic             sat,
    output logic [OUT_W-1:0] result
);

    always_comb begin
        if (sat) result = '1;
        else     result = mant >> shift;
    end

endmodule

// File: rtl/recip_pipe.sv
module recip_pipe #(
    parameter int Q_W   = recip_pkg::DEF_Q_W,
    parameter int IDX_W = recip_pkg::DEF_IDX_W,
    parameter int SCALE = recip_pkg::DEF_SCALE,
    localparam int OUT_W = SCALE + 1,
    localparam int SH_W  = $clog2(Q_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [Q_W-1:0]   operand,
    output logic             out_valid,
    output logic [OUT_W-1:0] recip
);

    typedef struct packed {
        logic             vld;
        logic             zero;
        logic [SH_W-1:0]  sh;
        logic [IDX_W-1:0] idx;
    } norm_st_t;

    typedef struct packed {
        logic             vld;
        logic             zero;
        logic [SH_W-1:0]  sh;
        logic [OUT_W-1:0] mant;
    } look_st_t;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] res;
    } out_st_t;

    typedef struct packed {
        norm_st_t a;
        look_st_t b;
        out_st_t  c;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [SH_W-1:0]  lo_pos_d;
    logic [IDX_W-1:0] lo_idx_d;
    logic             lo_zero_d;
    logic [OUT_W-1:0] tbl_mant_d;
    logic [OUT_W-1:0] dn_res_d;

    recip_lead_one #(.Q_W(Q_W), .IDX_W(IDX_W)) u_lead (
        .q_val   (operand),
        .msb_pos (lo_pos_d),
        .mant_idx(lo_idx_d),
        .is_zero (lo_zero_d)
    );

    recip_table #(.IDX_W(IDX_W), .SCALE(SCALE)) u_table (
        .idx (st_q.a.idx),
        .mant(tbl_mant_d)
    );

    recip_denorm #(.Q_W(Q_W), .SCALE(SCALE)) u_denorm (
        .mant  (st_q.b.mant),
        .shift (st_q.b.sh),
        .sat   (st_q.b.zero),
        .result(dn_res_d)
    );

    always_comb begin
        st_d        = st_q;
        st_d.a.vld  = in_valid;
        st_d.a.zero = lo_zero_d;
        st_d.a.sh   = lo_pos_d;
        st_d.a.idx  = lo_idx_d;
        st_d.b.vld  = st_q.a.vld;
        st_d.b.zero = st_q.a.zero;
        st_d.b.sh   = st_q.a.sh;
        st_d.b.mant = tbl_mant_d;
        st_d.c.vld  = st_q.b.vld;
        st_d.c.res  = dn_res_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.c.vld;
    assign recip     = st_q.c.res;

    // cycles since reset release, saturating, to bound $past windows
    logic [1:0] live_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 live_cnt_q <= '0;
        else if (live_cnt_q != 2'd3) live_cnt_q <= live_cnt_q + 2'd1;
    end

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_zero_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.b.vld && st_q.b.zero) |=> (out_valid && (recip == '1)));

    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (recip != '1)) |-> (recip <= (OUT_W'(1) << SCALE)));

    p_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(recip));

endmodule

// File: tb/recip_pipe_test.sv
`timescale 1ns/1ps
module recip_pipe_test;

    localparam int QW = 24;
    localparam int OW = 25;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [QW-1:0] operand;
    logic          out_valid;
    logic [OW-1:0] recip;

    always #5 clk = ~clk;

    recip_pipe uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .out_valid(out_valid), .recip(recip)
    );

    int total = 0;
    int bad   = 0;
    int seen_out = 0;
    int want_out = 0;

    // behavioural model: three pending slots
    logic          mv [3];
    logic [QW-1:0] mq [3];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin mv[i] <= 1'b0; mq[i] <= '0; end
        end else begin
            mv[2] <= mv[1]; mq[2] <= mq[1];
            mv[1] <= mv[0]; mq[1] <= mq[0];
            mv[0] <= in_valid; mq[0] <= operand;
        end
    end

    function automatic longint exact_of(input logic [QW-1:0] v);
        if (v == 0) return 64'h1FFFFFF;
        return (64'd1 << 24) / longint'(v);
    endfunction

    function automatic bit is_pow2(input logic [QW-1:0] v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    task automatic fail(input string tag, input longint act, input longint exp, input logic [QW-1:0] v);
        bad++;
        $display("FAIL %s q=%0d actual=%0d expected=%0d", tag, v, act, exp);
    endtask

    task automatic check_cycle();
        longint ex, got, diff;
        total++;
        if (out_valid !== mv[2]) begin
            fail("R4/R5/R6/R7 valid", longint'(out_valid), longint'(mv[2]), mq[2]);
            return;
        end
        if (out_valid === 1'b1) seen_out++;
        if (mv[2] !== 1'b1) return;
        want_out++;
        total++;
        ex   = exact_of(mq[2]);
        got  = longint'(recip);
        diff = (got > ex) ? got - ex : ex - got;
        if (mq[2] == 0) begin
            if (got != 64'h1FFFFFF) fail("R3 zero saturation", got, 64'h1FFFFFF, mq[2]);
        end else if (is_pow2(mq[2])) begin
            if (got != ex) fail("R2 power of two", got, ex, mq[2]);
        end else if (mq[2] < 512) begin
            if (diff > 1) fail("R8 small operand", got, ex, mq[2]);
        end else begin
            if (diff > (ex >> 7) + 2) fail("R1 tolerance", got, ex, mq[2]);
        end
    endtask

    task automatic put(input logic v, input logic [QW-1:0] qq);
        @(negedge clk);
        check_cycle();
        in_valid = v;
        operand  = qq;
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; operand = '0;
        // R7: outputs quiet during reset
        repeat (4) put(1'b1, 24'd77);
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0) fail("R7 reset quiet", longint'(out_valid), 0, 0);
        rst_n = 1'b1; in_valid = 1'b0;

        // directed edges back to back (R2, R3, R5, R8)
        put(1'b1, 24'd1);
        put(1'b1, 24'd0);
        put(1'b1, 24'd2);
        put(1'b1, 24'd3);
        put(1'b1, 24'd255);
        put(1'b1, 24'd256);
        put(1'b1, 24'd257);
        put(1'b1, 24'd511);
        put(1'b1, 24'd512);
        put(1'b1, 24'hFFFFFF);
        put(1'b1, 24'h800001);
        for (int p = 0; p < QW; p++) put(1'b1, QW'(1) << p);
        for (int p = 1; p < QW; p++) put(1'b1, (QW'(1) << p) + 1);
        for (int w = 1; w <= 256; w++) put(1'b1, QW'(65536 / w));
        for (int v = 1; v < 512; v += 7) put(1'b1, QW'(v));

        // bubbles and random widths (R1, R6)
        for (int i = 0; i < 600; i++) begin
            logic [QW-1:0] rq;
            rq = QW'($urandom) >> ($urandom % QW);
            if ($urandom % 17 == 0) rq = '0;
            put(($urandom % 3) != 0, rq);
        end

        // R7: reset with a full pipeline discards in-flight operands
        put(1'b1, 24'd1000);
        put(1'b1, 24'd2000);
        put(1'b1, 24'd3000);
        @(negedge clk);
        check_cycle();
        rst_n = 1'b0; in_valid = 1'b0;
        #1;
        total++;
        if (out_valid !== 1'b0) fail("R7 reset flush", longint'(out_valid), 0, 0);
        put(1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) put(1'b0, '0);

        // R5: every accepted operand produced exactly one result
        total++;
        if (seen_out != want_out) fail("R5 result count", seen_out, want_out, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule